// File: doc/BRIEF.md
# Infrared Receive Edge Capture and Carrier Burst Counter

This block is the receive side of an infrared timer. It passes the receive pin through a two-flop synchronizer and finds edges by comparing each synchronized sample with the one before it. A two-bit selector decides which of those edges count. Each counted edge stores the pin level. In capture mode it also copies a free-running 16-bit timer into the result register and raises a sticky event flag. Software can therefore measure the time between pulse edges.

In burst mode the block counts carrier edges instead of timing them. Turning burst mode on loads 1 into the result register, and each counted edge adds one. Each counted edge also restarts an interval counter. The event flag is raised only when twice the programmed carrier period passes with no further edge, which marks the end of a burst. A wrap of the free-running timer sets a separate sticky overflow flag. The interrupt line combines both flags behind an enable.

Top module: `ir_rx_capture`

## Requirements
- R1: `edge_sel` selects which synchronized edges count: 2'b00 falling only, 2'b01 rising only, 2'b10 both, and 2'b11 none at all.
- R2: Every counted edge stores the synchronized pin level into `rx_data`.
- R3: In capture mode (`burst_en`=0), a counted edge copies the free-running timer into `cap` and sets `flag`. The timer advances by one on every active cycle, so the difference between two captures equals the number of cycles between the two pin changes.
- R4: When `burst_en` goes from 0 to 1, `cap` becomes 1 on the next clock. This load takes priority over a counted edge in the same cycle.
- R5: In burst mode, a counted edge increments `cap` and does not set `flag`.
- R6: In burst mode, `flag` is set exactly 2*`carrier_period` cycles after the last counted edge, provided no further counted edge occurs in that time. Each counted edge restarts this interval. `carrier_period` must be at least 1.
- R7: `irq` is 1 exactly when `irq_en` is 1 and `flag` or `ovf` is 1.
- R8: The block is active only while `en`=1 and `mode`=0. While it is inactive, the timer is held at 0, no edge counts, and `cap` and `rx_data` do not change (except for the R4 load).
- R9: When the timer wraps from all ones to zero, `ovf` is set. `flag` and `ovf` stay set until a one-cycle pulse on `clr_flag` or `clr_ovf` clears them. A set in the same cycle wins over the clear.
- R10: A pin change appears in `cap`, `rx_data` and `flag` on the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_pin | input | 1 | Asynchronous infrared receive pin |
| en | input | 1 | Block enable |
| mode | input | 1 | 0 = receive (active), 1 = transmit (receive idle) |
| edge_sel | input | 2 | Counted-edge select |
| burst_en | input | 1 | Burst-count mode select |
| carrier_period | input | PW (16) | Carrier period in cycles |
| irq_en | input | 1 | Interrupt enable |
| clr_flag | input | 1 | Write-one-to-clear pulse for `flag` |
| clr_ovf | input | 1 | Write-one-to-clear pulse for `ovf` |
| cap | output | TW (16) | Capture value or burst edge count |
| rx_data | output | 1 | Pin level at the last counted edge |
| flag | output | 1 | Sticky event flag |
| ovf | output | 1 | Sticky timer overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
Wrong edge detection or synchronizer state shows up as an extra or missing `flag` set, or a wrong `rx_data`, exactly three clocks after a pin change. A timer that drifts or is not held at zero while idle shows up as a wrong difference between two captures. A wrong burst counter shows up in `cap` as soon as the burst ends. An interval counter that is off by one moves the rising edge of `flag` by a cycle, and the bench probes that edge one cycle on each side.

// File: rtl/ir_rx_capture.sv
module ir_rx_capture #(
  parameter int TW = 16,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_pin,
  input  logic          en,
  input  logic          mode,
  input  logic [1:0]    edge_sel,
  input  logic          burst_en,
  input  logic [PW-1:0] carrier_period,
  input  logic          irq_en,
  input  logic          clr_flag,
  input  logic          clr_ovf,
  output logic [TW-1:0] cap,
  output logic          rx_data,
  output logic          flag,
  output logic          ovf,
  output logic          irq
);
  localparam logic [PW:0] IVL_ONE = (PW+1)'(1);

  logic          s1, s2, prev, burst_q, ivl_run;
  logic [TW-1:0] tmr;
  logic [PW:0]   ivl;

  wire active     = en & ~mode;
  wire rise       = s2 & ~prev;
  wire fall       = ~s2 & prev;
  wire burst_rise = burst_en & ~burst_q;
  wire [PW:0] ivl_last = {carrier_period, 1'b0} - IVL_ONE;

  logic hit;
  always_comb begin
    case (edge_sel)
      2'b00:   hit = fall;
      2'b01:   hit = rise;
      2'b10:   hit = rise | fall;
      default: hit = 1'b0;
    endcase
  end

  wire qual    = active & hit;
  wire expire  = active & burst_en & ~qual & ivl_run & (ivl == ivl_last);
  wire set_flg = (qual & ~burst_en) | expire;
  wire set_ovf = active & (&tmr);

  assign irq = irq_en & (flag | ovf);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; prev <= 1'b0; burst_q <= 1'b0;
    end else begin
      s1 <= rx_pin; s2 <= s1; prev <= s2; burst_q <= burst_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr <= '0;
    else if (!active) tmr <= '0;
    else tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap <= '0; rx_data <= 1'b0;
    end else begin
      if (burst_rise) cap <= TW'(1);
      else if (qual) cap <= burst_en ? cap + 1'b1 : tmr;
      if (qual) rx_data <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl <= '0; ivl_run <= 1'b0;
    end else if (!active || !burst_en) begin
      ivl <= '0; ivl_run <= 1'b0;
    end else if (qual) begin
      ivl <= '0; ivl_run <= 1'b1;
    end else if (ivl_run) begin
      if (ivl == ivl_last) ivl_run <= 1'b0;
      else ivl <= ivl + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0; ovf <= 1'b0;
    end else begin
      flag <= set_flg | (flag & ~clr_flag);
      ovf  <= set_ovf | (ovf & ~clr_ovf);
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !burst_rise) |=> ($stable(cap) && $stable(rx_data))); // R8
  AST_RESERVED_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel == 2'b11 && !burst_rise) |=> $stable(cap)); // R1
  AST_BURST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    burst_rise |=> (cap == TW'(1))); // R4
  AST_BURST_NO_EDGE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_en && qual && !flag) |=> !flag); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_flag) |=> flag); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr_ovf) |=> ovf); // R9
endmodule

// File: tb/ir_rx_capture_bench.sv
module ir_rx_capture_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_pin = 1'b0, en = 1'b0, mode = 1'b0, burst_en = 1'b0;
  logic irq_en = 1'b0, clr_flag = 1'b0, clr_ovf = 1'b0;
  logic [1:0] edge_sel = 2'b00;
  logic [15:0] carrier_period = 16'd4;
  logic [15:0] cap;
  logic rx_data, flag, ovf, irq;
  int n_chk = 0, n_bad = 0;
  logic [15:0] c1;

  always #5 clk = ~clk;

  ir_rx_capture u_ir_rx_capture (.clk, .rst_n, .rx_pin, .en, .mode, .edge_sel,
    .burst_en, .carrier_period, .irq_en, .clr_flag, .clr_ovf,
    .cap, .rx_data, .flag, .ovf, .irq);

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_clr;
    clr_flag = 1'b1; tick(1); clr_flag = 1'b0;
  endtask

  // {edge_sel, pin level driven, edge counted}
  localparam logic [3:0] VEC [8] = '{
    {2'b00, 1'b1, 1'b0}, {2'b00, 1'b0, 1'b1},
    {2'b01, 1'b1, 1'b1}, {2'b01, 1'b0, 1'b0},
    {2'b10, 1'b1, 1'b1}, {2'b10, 1'b0, 1'b1},
    {2'b11, 1'b1, 1'b0}, {2'b11, 1'b0, 1'b0}};

  initial begin
    fork
      begin
        tick(2);
        chk("R9 reset cap", cap, 0);
        chk("R9 reset flags", {flag, ovf, irq}, 0);
        rst_n = 1'b1; en = 1'b1; tick(4);

        // R1 R2 R10: edge select table
        for (int i = 0; i < 8; i++) begin
          edge_sel = VEC[i][3:2];
          rx_pin = VEC[i][1];
          tick(2);
          chk("R10 no early flag", flag, 0);
          tick(1);
          chk("R1 edge select", flag, VEC[i][0]);
          if (VEC[i][0]) chk("R2 rx_data", rx_data, VEC[i][1]);
          pulse_clr;
          chk("R9 flag cleared", flag, 0);
        end

        // R3: capture difference
        edge_sel = 2'b10;
        rx_pin = 1'b1; tick(3); c1 = cap;
        tick(17); rx_pin = 1'b0; tick(3);
        chk("R3 capture delta", cap - c1, 20);
        chk("R3 flag set", flag, 1);

        // R7
        chk("R7 irq masked", irq, 0);
        irq_en = 1'b1; #1;
        chk("R7 irq asserted", irq, 1);
        pulse_clr; #1;
        chk("R7 irq dropped", irq, 0);

        // R8: inactive modes
        c1 = cap;
        mode = 1'b1; tick(1);
        rx_pin = 1'b1; tick(5);
        chk("R8 mode=1 no capture", {cap, flag}, {c1, 1'b0});
        mode = 1'b0; en = 1'b0; tick(1);
        rx_pin = 1'b0; tick(5);
        chk("R8 en=0 no capture", {cap, flag}, {c1, 1'b0});
        en = 1'b1; rx_pin = 1'b1; tick(3);
        chk("R8 timer restarted from 0", cap, 2);
        pulse_clr;

        // R4 R5 R6: burst counting
        burst_en = 1'b1; tick(1);
        chk("R4 burst load", cap, 1);
        for (int k = 0; k < 5; k++) begin
          rx_pin = ~rx_pin; tick(3);
          chk("R5 no flag per edge", flag, 0);
        end
        chk("R5 edge count", cap, 6);
        tick(7);
        chk("R6 interval not yet", flag, 0);
        tick(1);
        chk("R6 interval expired", flag, 1);
        chk("R5 count held", cap, 6);
        pulse_clr;
        burst_en = 1'b0; tick(1);
        burst_en = 1'b1; rx_pin = ~rx_pin; tick(1);
        chk("R4 reload", cap, 1);

        // R9: overflow
        burst_en = 1'b0; irq_en = 1'b0;
        chk("R9 no ovf yet", ovf, 0);
        en = 1'b0; tick(1); en = 1'b1;
        tick(65535);
        chk("R9 ovf before wrap", ovf, 0);
        tick(1);
        chk("R9 ovf set on wrap", ovf, 1);
        tick(3);
        chk("R9 ovf sticky", ovf, 1);
        clr_ovf = 1'b1; tick(1); clr_ovf = 1'b0;
        chk("R9 ovf cleared", ovf, 0);
      end
      begin
        tick(150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule